// File: doc/BRIEF.md
# Bus Ownership and Drive Controller

This block decides when a bus master may drive the shared external bus. It watches a grant input from an outside arbiter and an access handshake from the master's bus engine. From these it produces three outputs: a bus request, a bus-driven flag and a set of output enables for the address, data and control pin groups. A four-state machine tracks ownership and whether an access is in flight. The states are released, owner idle, owner transferring, and draining after the grant was withdrawn.

The engine offers an access on `acc_valid`. The access starts on a rising edge where both `acc_valid` and `acc_ready` are high. The engine should hold `acc_valid` until it sees `acc_ready`; this is the back-pressure rule. The block stalls the engine by holding `acc_ready` low whenever it does not own an idle bus with the grant present. The engine reports the end of the last transfer of the access with a one-cycle `acc_done` pulse. A withdrawn grant never cuts an access short: the pins stay driven until that pulse. The flag and the enables change only on rising clock edges. The one exception is reset, which clears them at once.

Top module: `bus_owner_ctl`

## Requirements
- R1: While `rst_n` is low, `bus_req`, `bus_driven` and every bit of `pins_oe` are low. They clear as soon as `rst_n` falls, without waiting for a clock edge.
- R2: When the block is released and `bus_grant` is sampled high at a rising edge, `bus_driven` and all `pins_oe` bits are high from that edge on.
- R3: While the block owns the bus and `bus_grant` is high, `bus_driven` stays high, even with no access in flight. `bus_driven` never falls at an edge where `bus_grant` was sampled high.
- R4: Every bit of `pins_oe` equals `bus_driven` at all times, so no pin group is driven while the flag is low.
- R5: `acc_ready` is high only when the block owns the bus, no access is in flight and `bus_grant` is high. An access is in flight from the edge that accepts it until the edge where `acc_done` is sampled high. `acc_done` is ignored when no access is in flight.
- R6: If `bus_grant` is low while an access is in flight, `bus_driven` and `pins_oe` stay high. They drop at the edge where `acc_done` is sampled high, provided the grant is still low then.
- R7: If the block owns the bus with no access in flight and `bus_grant` is sampled low, `bus_driven` and `pins_oe` drop at that edge.
- R8: `bus_req` is registered. After an edge it is high exactly when `acc_valid` was sampled high and the block is released after that edge. It therefore rises one cycle after an unowned access request and falls at the edge that takes ownership.
- R9: If `bus_grant` returns while an access is draining, `bus_driven` does not drop. The block goes back to owner idle once `acc_done` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| bus_grant | input | 1 | Grant from the external arbiter |
| acc_valid | input | 1 | Engine offers a new access |
| acc_ready | output | 1 | Block accepts the offered access this cycle |
| acc_done | input | 1 | Last transfer of the in-flight access completes |
| bus_req | output | 1 | Request for the bus toward the arbiter |
| bus_driven | output | 1 | Master currently owns and drives the bus |
| pins_oe | output | N_OE | Output enables, one per pin group (address, data, control) |

## Verification
A wrong state shows at the ports within one clock edge. A lost in-flight marker shows as `bus_driven` falling before `acc_done`. A stuck drain state keeps the pins driven a cycle after `acc_done` with no grant. A released state entered while granted shows as the flag falling with the grant high. The bench compares every port with a small arithmetic model on every cycle. It sweeps all 4096 four-cycle sequences of grant, valid and done after a fresh reset, so each such divergence is caught on the cycle it first appears.

// File: rtl/bus_owner_pkg.sv
package bus_owner_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_XFER  = 2'd2,
    ST_DRAIN = 2'd3
  } own_state_e;
endpackage

// File: rtl/bus_owner_fsm.sv
module bus_owner_fsm
  import bus_owner_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_grant,
  input  logic       acc_valid,
  input  logic       acc_done,
  output logic       acc_ready,
  output own_state_e nstate
);
  own_state_e state;

  // Accept only from an owned, idle bus with the grant still present (R5)
  assign acc_ready = (state == ST_IDLE) && bus_grant;

  always_comb begin
    nstate = state;
    unique case (state)
      ST_FREE:  if (bus_grant) nstate = ST_IDLE;
      ST_IDLE: begin
        if (!bus_grant)     nstate = ST_FREE;
        else if (acc_valid) nstate = ST_XFER;
      end
      ST_XFER: begin
        if (acc_done)        nstate = bus_grant ? ST_IDLE : ST_FREE;
        else if (!bus_grant) nstate = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (acc_done)       nstate = bus_grant ? ST_IDLE : ST_FREE;
        else if (bus_grant) nstate = ST_XFER;
      end
      default: nstate = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FREE;
    else        state <= nstate;
  end
endmodule

// File: rtl/bus_drive_stage.sv
module bus_drive_stage
  import bus_owner_pkg::*;
#(
  parameter int N_OE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  own_state_e      nstate,
  input  logic            acc_valid,
  output logic            bus_driven,
  output logic            bus_req,
  output logic [N_OE-1:0] pins_oe
);
  logic owned_n;
  assign owned_n = (nstate != ST_FREE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_driven <= 1'b0;
      bus_req    <= 1'b0;
    end else begin
      bus_driven <= owned_n;
      bus_req    <= acc_valid && !owned_n;
    end
  end

  // One enable flop per pin group so each group can be placed near its pads
  for (genvar gi = 0; gi < N_OE; gi++) begin : g_oe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_oe[gi] <= 1'b0;
      else        pins_oe[gi] <= owned_n;
    end
  end
endmodule

// File: rtl/bus_owner_ctl.sv
module bus_owner_ctl
  import bus_owner_pkg::*;
#(
  parameter int N_OE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_grant,
  input  logic            acc_valid,
  output logic            acc_ready,
  input  logic            acc_done,
  output logic            bus_req,
  output logic            bus_driven,
  output logic [N_OE-1:0] pins_oe
);
  own_state_e nstate;

  bus_owner_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_grant (bus_grant),
    .acc_valid (acc_valid),
    .acc_done  (acc_done),
    .acc_ready (acc_ready),
    .nstate    (nstate)
  );

  bus_drive_stage #(.N_OE(N_OE)) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .nstate     (nstate),
    .acc_valid  (acc_valid),
    .bus_driven (bus_driven),
    .bus_req    (bus_req),
    .pins_oe    (pins_oe)
  );
endmodule

// File: rtl/bus_owner_chk.sv
module bus_owner_chk #(
  parameter int N_OE = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_grant,
  input logic            acc_valid,
  input logic            acc_ready,
  input logic            acc_done,
  input logic            bus_req,
  input logic            bus_driven,
  input logic [N_OE-1:0] pins_oe
);
  // Independent view of an access in flight, built from the handshake only
  logic in_flight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      in_flight <= 1'b0;
    else if (in_flight && acc_done)  in_flight <= 1'b0;
    else if (acc_valid && acc_ready) in_flight <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> (!bus_driven && !bus_req && pins_oe == '0)); // R1
  AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (!bus_driven && bus_grant) |=> bus_driven); // R2
  AST_FLAG_HELD_BY_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_driven) |-> !$past(bus_grant)); // R3
  AST_OE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (|pins_oe) |-> bus_driven); // R4
  AST_FLAG_DRIVES_ALL: assert property (@(posedge clk) disable iff (!rst_n) bus_driven |-> (&pins_oe)); // R4
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n) acc_ready |-> (bus_driven && bus_grant && !in_flight)); // R5
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (in_flight && !acc_done) |=> bus_driven); // R6
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (bus_driven && !in_flight && !bus_grant) |=> !bus_driven); // R7
  AST_REQ_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n) bus_req |-> !bus_driven); // R8
  AST_REQ_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_req) |-> $past(acc_valid)); // R8
  AST_REGRANT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (in_flight && bus_grant) |=> bus_driven); // R9
endmodule

bind bus_owner_ctl bus_owner_chk #(.N_OE(N_OE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_grant  (bus_grant),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_done   (acc_done),
  .bus_req    (bus_req),
  .bus_driven (bus_driven),
  .pins_oe    (pins_oe)
);

// File: tb/bus_owner_ctl_tb.sv
module bus_owner_ctl_tb;
  localparam int N_OE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_grant = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_done = 1'b0;
  logic acc_ready, bus_req, bus_driven;
  logic [N_OE-1:0] pins_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Reference model state
  bit m_own, m_busy, m_req, m_lost;
  string m_tag;

  always #10 clk = ~clk;

  bus_owner_ctl #(.N_OE(N_OE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_done(acc_done), .bus_req(bus_req),
    .bus_driven(bus_driven), .pins_oe(pins_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    check(bus_driven == m_own, m_tag, int'(bus_driven), int'(m_own));
    check(pins_oe == {N_OE{m_own}}, "R4", int'(pins_oe), m_own ? (1 << N_OE) - 1 : 0);
    check(bus_req == m_req, "R8", int'(bus_req), int'(m_req));
  endtask

  task automatic reset_pulse();
    @(negedge clk);
    rst_n = 1'b0; bus_grant = 1'b0; acc_valid = 1'b0; acc_done = 1'b0;
    #1;
    check(!bus_driven && !bus_req && pins_oe == '0, "R1",
          int'({bus_driven, bus_req, |pins_oe}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_own = 0; m_busy = 0; m_req = 0; m_lost = 0; m_tag = "R1";
  endtask

  // Check last edge's outputs, drive new inputs, check ready, model the edge
  task automatic step(input bit g, input bit v, input bit d);
    bit rdy, own_n, busy_n;
    @(negedge clk);
    check_outputs();
    bus_grant = g; acc_valid = v; acc_done = d;
    #1;
    rdy = m_own && !m_busy && g;
    check(acc_ready == rdy, "R5", int'(acc_ready), int'(rdy));
    @(posedge clk);
    if (!m_own) begin
      own_n = g; busy_n = 0; m_tag = "R2";
    end else if (m_busy) begin
      if (d) begin busy_n = 0; own_n = g; end
      else   begin busy_n = 1; own_n = 1; end
      m_tag = (m_lost && g) ? "R9" : "R6";
    end else if (v && rdy) begin
      busy_n = 1; own_n = 1; m_tag = "R5";
    end else begin
      own_n = g; busy_n = 0; m_tag = g ? "R3" : "R7";
    end
    m_req  = v && !own_n;
    m_lost = busy_n && !g;
    m_own  = own_n;
    m_busy = busy_n;
  endtask

  initial begin
    #(150000 * 20);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    m_tag = "R1";
    // Directed: grant loss in the middle of an access delays release (R6)
    reset_pulse();
    step(0, 1, 0);            // unowned request raises bus_req next edge (R8)
    step(1, 1, 0);            // grant taken (R2)
    step(1, 1, 0);            // accept access (R5)
    step(0, 0, 0);            // grant lost, still draining (R6)
    step(0, 0, 0);
    step(0, 0, 1);            // last transfer ends, release (R6)
    step(0, 0, 0);
    @(negedge clk);
    check_outputs();

    // Directed: asynchronous reset while owning (R1)
    reset_pulse();
    step(1, 0, 0);
    step(1, 0, 0);
    @(negedge clk);
    check(bus_driven == 1'b1, "R3", int'(bus_driven), 1);
    #5 rst_n = 1'b0;
    #1;
    check(!bus_driven && !bus_req && pins_oe == '0, "R1",
          int'({bus_driven, bus_req, |pins_oe}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_own = 0; m_busy = 0; m_req = 0; m_lost = 0; m_tag = "R1";

    // Sweep: every 4-cycle sequence of {grant, valid, done} from reset
    for (int s = 0; s < 4096; s++) begin
      reset_pulse();
      for (int k = 0; k < 4; k++) begin
        step(s[3*k+2], s[3*k+1], s[3*k]);
      end
      @(negedge clk);
      check_outputs();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule